// File: doc/BRIEF.md
# Byte-Wide SRAM with Hidden Single-Error Correction

This block models a small static memory, one byte wide, that keeps four extra check bits beside every stored byte. On each write the byte is encoded into a 12-bit single-error-correcting Hamming codeword and stored whole. On each read the addressed codeword is decoded, any single flipped bit is repaired, and the repaired byte is returned. The check bits never appear at the data interface, so a user sees an ordinary byte-wide SRAM.

The control interface follows the usual asynchronous SRAM truth table with active-low chip select, output enable and write enable. The tri-state data bus is split into a data-in bus, a data-out bus and a drive qualifier. Writes commit on the rising clock edge. Reads are combinational from the address. A test port can flip chosen stored bits at an address so that a bench can exercise the corrector. A debug flag shows when a read needed a repair.

Top module: `ecc_sram`

## Requirements
- R1: While `sel_n` is high, `q_drive` is 0 and `q` is 0, and no stored byte changes even if `wr_n` is low at a clock edge.
- R2: With `sel_n` low, `wr_n` high and `rd_oe_n` high, `q_drive` is 0 and stored content is unchanged.
- R3: With `sel_n` low, `wr_n` high and `rd_oe_n` low, `q_drive` is 1 and `q` shows the stored byte at `addr` in the same cycle. Whenever `q_drive` is 0, `q` is 0.
- R4: With `sel_n` low and `wr_n` low at a rising edge, `d` is stored at `addr` whatever `rd_oe_n` is, and `q_drive` is 0 during that cycle.
- R5: A single flipped bit at any of the 12 codeword positions is corrected on read, and `q` returns the byte that was written.
- R6: A flipped check bit (positions 1, 2, 4 or 8) leaves the returned byte unchanged.
- R7: `fix_seen` is 1 only during an active read whose codeword has a nonzero syndrome. It is 0 on clean reads and while no read is active.
- R8: With `flip_en` high at a rising edge, `flip_mask` is XORed into the stored codeword at `addr`, where mask bit k-1 flips position k. Flips apply regardless of `sel_n`. If a write commits at the same edge, the write wins and the word is stored clean.
- R9: While `rst_n` is low, writes and flips have no effect and `q_drive` is 0.
- R10: Codeword layout: check bits sit at positions 1, 2, 4 and 8. Data bits 0 to 7 sit, in that order, at positions 3, 5, 6, 7, 9, 10, 11 and 12. Each check bit is the even parity of the positions whose index has that bit set. A nonzero syndrome inverts the position it names, if that position is 12 or less. As a result, flipping positions 1 and 2 returns the byte XOR 0x01, flipping 3 and 5 returns XOR 0x07, and flipping 3 and 12 returns XOR 0x81.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes and flips commit on the rising edge |
| rst_n | input | 1 | Active-low reset; blocks writes, flips and output drive |
| sel_n | input | 1 | Active-low chip select |
| rd_oe_n | input | 1 | Active-low output enable |
| wr_n | input | 1 | Active-low write enable |
| addr | input | AW (10) | Word address |
| d | input | DATA_W (8) | Write data |
| q | output | DATA_W (8) | Corrected read data, 0 when not driven |
| q_drive | output | 1 | High when `q` would drive the bus |
| flip_en | input | 1 | Test: apply `flip_mask` to the stored codeword at `addr` |
| flip_mask | input | CW_W (12) | Test: bit k-1 flips codeword position k |
| fix_seen | output | 1 | Debug: an active read needed a correction |

## Verification
A write and a stored-bit flip can land on the same rising edge at the same address. The bench provokes this by raising `flip_en` with a one-bit mask in the cycle where `sel_n` and `wr_n` are both low. It then reads the address back. The result is judged correct when the new byte returns and `fix_seen` stays 0, which shows that the fresh codeword replaced the word rather than being XORed with the mask.

// File: rtl/ecc_sram_pkg.sv
package ecc_sram_pkg;

   // smallest check width p with 2**p >= data + p + 1
   function automatic int chk_bits(input int dw);
      int p;
      p = 1;
      while ((1 << p) < dw + p + 1) p++;
      return p;
   endfunction

   function automatic bit is_pow2(input int k);
      return (k > 0) && ((k & (k - 1)) == 0);
   endfunction

   // positions (1-based, bit k-1) covered by check bit i
   function automatic logic [63:0] cover_mask(input int i, input int n);
      logic [63:0] m;
      m = '0;
      for (int k = 1; k <= n; k++)
         if (((k >> i) & 1) == 1) m[k-1] = 1'b1;
      return m;
   endfunction

endpackage

// File: rtl/ecc_enc.sv
module ecc_enc #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW_W   = DATA_W + CHK_W
) (
   input  logic [DATA_W-1:0] data,
   output logic [CW_W-1:0]   cw
);
   import ecc_sram_pkg::*;

   logic [CW_W-1:0]  placed;
   logic [CW_W-1:0]  chkvec;
   logic [CHK_W-1:0] chk;

   // data bits fill the non-power-of-two positions, LSB first
   always_comb begin
      int j;
      j = 0;
      placed = '0;
      for (int k = 1; k <= CW_W; k++) begin
         if (!is_pow2(k)) begin
            placed[k-1] = data[j];
            j++;
         end
      end
   end

   for (genvar i = 0; i < CHK_W; i++) begin : g_par
      localparam logic [63:0] MASK64 = cover_mask(i, CW_W);
      localparam logic [CW_W-1:0] MASK = MASK64[CW_W-1:0];
      assign chk[i] = ^(placed & MASK);
   end

   always_comb begin
      chkvec = '0;
      for (int i = 0; i < CHK_W; i++) chkvec[(1 << i) - 1] = chk[i];
   end

   assign cw = placed | chkvec;

endmodule

// File: rtl/ecc_dec.sv
module ecc_dec #(
   parameter int DATA_W = 8,
   parameter int CHK_W  = 4,
   parameter int CW_W   = DATA_W + CHK_W
) (
   input  logic [CW_W-1:0]   cw,
   output logic [DATA_W-1:0] data,
   output logic [DATA_W-1:0] raw_data,
   output logic [CHK_W-1:0]  syn
);
   import ecc_sram_pkg::*;

   logic [CW_W-1:0] fixed;

   for (genvar i = 0; i < CHK_W; i++) begin : g_syn
      localparam logic [63:0] MASK64 = cover_mask(i, CW_W);
      localparam logic [CW_W-1:0] MASK = MASK64[CW_W-1:0];
      assign syn[i] = ^(cw & MASK);
   end

   // invert the named position; syndromes past the word end repair nothing
   always_comb begin
      fixed = cw;
      for (int k = 1; k <= CW_W; k++)
         if (int'(syn) == k) fixed[k-1] = ~cw[k-1];
   end

   always_comb begin
      int j;
      j = 0;
      data     = '0;
      raw_data = '0;
      for (int k = 1; k <= CW_W; k++) begin
         if (!is_pow2(k)) begin
            data[j]     = fixed[k-1];
            raw_data[j] = cw[k-1];
            j++;
         end
      end
   end

endmodule

// File: rtl/ecc_array.sv
module ecc_array #(
   parameter int DEPTH = 1024,
   parameter int CW_W  = 12,
   parameter int AW    = $clog2(DEPTH)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr_en,
   input  logic            flip_en,
   input  logic [AW-1:0]   addr,
   input  logic [CW_W-1:0] wr_cw,
   input  logic [CW_W-1:0] flip_mask,
   output logic [CW_W-1:0] rd_cw
);

   logic [CW_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (rst_n) begin
         if (wr_en)        mem[addr] <= wr_cw;
         else if (flip_en) mem[addr] <= mem[addr] ^ flip_mask;
      end
   end

   assign rd_cw = mem[addr];

   // R4: a committed write is what the same address reads next cycle
   assert_write_lands_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (addr != $past(addr)) || (rd_cw == $past(wr_cw)));

   // R8: a lone flip toggles exactly the masked bits
   assert_flip_applies_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_en && !wr_en) |=> (addr != $past(addr)) ||
                              (rd_cw == ($past(rd_cw) ^ $past(flip_mask))));

   // R2: with neither write nor flip the word holds
   assert_idle_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_en && !flip_en) |=> (addr != $past(addr)) || (rd_cw == $past(rd_cw)));

endmodule

// File: rtl/ecc_sram.sv
module ecc_sram #(
   parameter  int DATA_W = 8,
   parameter  int DEPTH  = 1024,
   localparam int AW     = $clog2(DEPTH),
   localparam int CHK_W  = ecc_sram_pkg::chk_bits(DATA_W),
   localparam int CW_W   = DATA_W + CHK_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              rd_oe_n,
   input  logic              wr_n,
   input  logic [AW-1:0]     addr,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q,
   output logic              q_drive,
   input  logic              flip_en,
   input  logic [CW_W-1:0]   flip_mask,
   output logic              fix_seen
);

   if (DATA_W < 1)          $error("DATA_W must be at least 1");
   if (DEPTH < 2)           $error("DEPTH must be at least 2");
   if ((1 << AW) != DEPTH)  $error("DEPTH must be a power of two");
   if (CW_W > 64)           $error("codeword wider than 64 bits");

   logic              wr_en;
   logic              flip_go;
   logic [CW_W-1:0]   enc_cw;
   logic [CW_W-1:0]   rd_cw;
   logic [DATA_W-1:0] rd_data;
   logic [DATA_W-1:0] rd_raw;
   logic [CHK_W-1:0]  syn;
   logic              syn_nz;

   assign wr_en   = rst_n && !sel_n && !wr_n;
   assign flip_go = rst_n && flip_en;
   assign q_drive = rst_n && !sel_n && wr_n && !rd_oe_n;

   ecc_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_enc (
      .data (d),
      .cw   (enc_cw)
   );

   ecc_array #(.DEPTH(DEPTH), .CW_W(CW_W), .AW(AW)) u_array (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .flip_en   (flip_go),
      .addr      (addr),
      .wr_cw     (enc_cw),
      .flip_mask (flip_mask),
      .rd_cw     (rd_cw)
   );

   ecc_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W), .CW_W(CW_W)) u_dec (
      .cw       (rd_cw),
      .data     (rd_data),
      .raw_data (rd_raw),
      .syn      (syn)
   );

   assign syn_nz   = (syn != '0);
   assign q        = q_drive ? rd_data : '0;
   assign fix_seen = q_drive && syn_nz;

   // R5: one flip on a clean word is repaired back to the same byte
   assert_single_fix_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (flip_go && !wr_en && ($countones(flip_mask) == 1) && !syn_nz)
      |=> (addr != $past(addr)) || ((rd_data == $past(rd_data)) && syn_nz));

   // R6: a clean word decodes to its raw data bits
   assert_clean_passthru_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !syn_nz |-> (rd_data == rd_raw));

endmodule

// File: tb/tb_ecc_sram.sv
module tb_ecc_sram;
   localparam int DW = 8;
   localparam int DEPTH = 1024;
   localparam int AW = 10;
   localparam int CW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          sel_n = 1'b1;
   logic          rd_oe_n = 1'b1;
   logic          wr_n = 1'b1;
   logic [AW-1:0] addr = '0;
   logic [DW-1:0] d = '0;
   logic [DW-1:0] q;
   logic          q_drive;
   logic          flip_en = 1'b0;
   logic [CW-1:0] flip_mask = '0;
   logic          fix_seen;

   int nchk = 0;
   int nfail = 0;

   always #5 clk = ~clk;

   ecc_sram #(.DATA_W(DW), .DEPTH(DEPTH)) dut (
      .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_oe_n(rd_oe_n), .wr_n(wr_n),
      .addr(addr), .d(d), .q(q), .q_drive(q_drive), .flip_en(flip_en),
      .flip_mask(flip_mask), .fix_seen(fix_seen)
   );

   task automatic check(input string req, input int act, input int exp);
      nchk++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic idle();
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b1; rd_oe_n = 1'b1; flip_en = 1'b0;
   endtask

   task automatic wr(input int a, input int v);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; rd_oe_n = 1'b1; flip_en = 1'b0;
      addr = AW'(a); d = DW'(v);
      idle();
   endtask

   task automatic rd_expect(input string req, input int a, input int v, input int fx);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b0; flip_en = 1'b0; addr = AW'(a);
      #1;
      check({req, " drive"}, int'(q_drive), 1);
      check({req, " data"}, int'(q), v);
      check({req, " fix_seen"}, int'(fix_seen), fx);
   endtask

   task automatic flip(input int a, input int m);
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b1; rd_oe_n = 1'b1;
      flip_en = 1'b1; addr = AW'(a); flip_mask = CW'(m);
      idle();
   endtask

   task automatic t_basic();
      wr(0, 8'hA5); wr(1023, 8'h3C); wr(5, 8'h00); wr(6, 8'hFF);
      rd_expect("R3 addr0", 0, 8'hA5, 0);
      rd_expect("R3 top addr", 1023, 8'h3C, 0);
      rd_expect("R7 zeros clean", 5, 8'h00, 0);
      rd_expect("R7 ones clean", 6, 8'hFF, 0);
   endtask

   task automatic t_write_oe_low();
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; rd_oe_n = 1'b0; addr = 10'd7; d = 8'h69;
      #1;
      check("R4 no drive in write", int'(q_drive), 0);
      check("R4 q zero in write", int'(q), 0);
      idle();
      rd_expect("R4 write with oe low", 7, 8'h69, 0);
   endtask

   task automatic t_deselect();
      @(negedge clk);
      sel_n = 1'b1; wr_n = 1'b0; rd_oe_n = 1'b0; addr = 10'd7; d = 8'h12;
      #1;
      check("R1 no drive deselected", int'(q_drive), 0);
      check("R1 q zero deselected", int'(q), 0);
      check("R7 no flag idle", int'(fix_seen), 0);
      idle();
      rd_expect("R1 deselected write ignored", 7, 8'h69, 0);
   endtask

   task automatic t_oe_high();
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b1; addr = 10'd0; d = 8'h77;
      #1;
      check("R2 no drive oe high", int'(q_drive), 0);
      check("R2 q zero oe high", int'(q), 0);
      idle();
      rd_expect("R2 content kept", 0, 8'hA5, 0);
   endtask

   task automatic t_single_flips();
      for (int p = 1; p <= CW; p++) begin
         wr(20 + p, 8'hC3 ^ p);
         flip(20 + p, 1 << (p - 1));
         if (p == 1 || p == 2 || p == 4 || p == 8)
            rd_expect($sformatf("R6 check pos %0d", p), 20 + p, 8'hC3 ^ p, 1);
         else
            rd_expect($sformatf("R5 data pos %0d", p), 20 + p, 8'hC3 ^ p, 1);
      end
      // flip persists until rewritten; flip applied while deselected
      rd_expect("R7 flag persists", 23, 8'hC3 ^ 3, 1);
   endtask

   task automatic t_write_and_flip();
      wr(40, 8'h55);
      @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b0; rd_oe_n = 1'b1; addr = 10'd40; d = 8'h9E;
      flip_en = 1'b1; flip_mask = 12'h004;
      idle();
      rd_expect("R8 write wins over flip", 40, 8'h9E, 0);
   endtask

   task automatic t_double();
      wr(50, 8'h5A); flip(50, 12'h003);
      rd_expect("R10 pos1+2 -> bit0", 50, 8'h5A ^ 8'h01, 1);
      wr(51, 8'h5A); flip(51, 12'h014);
      rd_expect("R10 pos3+5 -> xor7", 51, 8'h5A ^ 8'h07, 1);
      wr(52, 8'h5A); flip(52, 12'h804);
      rd_expect("R10 pos3+12 -> xor81", 52, 8'h5A ^ 8'h81, 1);
   endtask

   task automatic t_reset_block();
      wr(9, 8'h11);
      @(negedge clk);
      rst_n = 1'b0;
      sel_n = 1'b0; wr_n = 1'b0; addr = 10'd9; d = 8'h22;
      flip_en = 1'b1; flip_mask = 12'h010;
      @(negedge clk);
      wr_n = 1'b1; flip_en = 1'b0; rd_oe_n = 1'b0;
      #1;
      check("R9 no drive in reset", int'(q_drive), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      rd_expect("R9 reset blocks write and flip", 9, 8'h11, 0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      sel_n = 1'b0; wr_n = 1'b1; rd_oe_n = 1'b0;
      #1;
      check("R9 reset drive low", int'(q_drive), 0);
      check("R9 reset q zero", int'(q), 0);
      @(negedge clk);
      rst_n = 1'b1;
      idle();
      t_basic();
      t_write_oe_low();
      t_deselect();
      t_oe_high();
      t_single_flips();
      t_write_and_flip();
      t_double();
      t_reset_block();
      idle();
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      nchk++;
      nfail++;
      $display("FAIL watchdog: got 0x1 expected 0x0");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
   end

endmodule